// File: doc/BRIEF.md
# Supply-Guarded Battery-Backed SRAM Controller

This block sits between a host's asynchronous static-RAM control lines and a RAM array whose contents must survive loss of the main supply. Digitized supply-level flags arrive as a thermometer code. From them the block decides whether host cycles may reach the array, when the array must be moved onto its backup cell, and whether that cell has been armed yet. While the supply is healthy the host's chip-enable, write-enable and output-enable pass straight through to the array. At any other time the array controls are held inactive and the host data drivers are turned off.

A state machine with four states makes the decisions. SEALED is the state of a part that has never been powered. Its backup cell is disconnected. NORMAL passes host cycles through. PROTECTED blocks every host cycle. BACKUP blocks every host cycle and also selects the backup cell. Seven transitions link the states:

- T1: SEALED to NORMAL when the supply is above the seal-release level and also above the resume level.
- T2: SEALED to PROTECTED when the supply is above the seal-release level but below the resume level.
- T3: NORMAL to PROTECTED when the supply falls below the protect level.
- T4: PROTECTED to NORMAL when the supply reaches the resume level.
- T5: PROTECTED to BACKUP when the supply falls below the switchover level.
- T6: BACKUP to PROTECTED when the supply climbs back above the switchover level.
- T7: A warm reset lands in PROTECTED once the seal has been released, and in SEALED otherwise. Only a cold reset re-arms the seal.

Parameter `TIGHT_TOL` selects the variant. With `TIGHT_TOL`=1 the protect level is 4.5 V and the resume level is 4.75 V. With `TIGHT_TOL`=0 the protect level is 4.25 V and the resume level is 4.5 V.

Top module: `nvsram_guard`

## Requirements
- R1: `supply_lvl` passes through a two-stage synchronizer. A change that is stable before clock edge k acts on the state register at edge k+2, so it reaches the outputs just after edge k+2.
- R2: After a cold reset the block is SEALED. In SEALED, `backup_sel` stays 0 at every supply level, including below the switchover flag (bit 0 low). The seal is released when bit 1 is high (above 4.25 V).
- R3: Once released, the seal stays released through warm resets. A warm reset with the supply below switchover therefore ends with `backup_sel`=1. A cold reset seals the block again.
- R4: The block leaves NORMAL when the protect flag goes low. That flag is bit 2 (4.5 V) when `TIGHT_TOL`=1 and bit 1 (4.25 V) when `TIGHT_TOL`=0.
- R5: The block re-enters NORMAL only when the resume flag is high. That flag is bit 3 (4.75 V) when `TIGHT_TOL`=1 and bit 2 (4.5 V) when `TIGHT_TOL`=0. Between the protect and resume levels the block stays blocked.
- R6: Outside NORMAL, `ram_ce_n`, `ram_we_n` and `ram_oe_n` are 1 and `dq_drive_en` is 0, whatever the host inputs are.
- R7: In NORMAL, `ram_ce_n` follows `host_ce_n`. A read (chip-enable low, output-enable low, write-enable high) gives `ram_oe_n`=0 and `dq_drive_en`=1.
- R8: In NORMAL, `ram_we_n` is low exactly while `host_ce_n` and `host_we_n` are both low. The write therefore begins at whichever of the two falls later and ends at whichever rises first.
- R9: A falling `host_we_n` removes `dq_drive_en` and `ram_oe_n` in the same cycle, with no clock edge needed.
- R10: A write in progress is cut off at once. `ram_we_n` goes to 1 in the same cycle that the protected state is entered.
- R11: `backup_sel` is 1 only in BACKUP. BACKUP is entered from PROTECTED when bit 0 (about 3.0 V) goes low, and is left when bit 0 returns high.
- R12: `TIGHT_TOL` alone selects the variant. At a supply between 4.25 V and 4.5 V, a wide-tolerance instance that is already in NORMAL keeps passing writes, while a tight-tolerance instance blocks them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Warm reset, active low, synchronous; keeps the seal |
| cold_rst_n | input | 1 | Cold reset, active low; clears the seal |
| supply_lvl | input | 4 | Thermometer supply flags: bit0 above 3.0 V, bit1 above 4.25 V, bit2 above 4.5 V, bit3 above 4.75 V |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| ram_ce_n | output | 1 | Array chip enable, active low |
| ram_we_n | output | 1 | Array write strobe, active low |
| ram_oe_n | output | 1 | Array output enable, active low |
| dq_drive_en | output | 1 | Host data drivers enabled (0 means high-impedance) |
| backup_sel | output | 1 | 1 selects the backup cell as the array supply |

## Verification
The assertions take for granted that `supply_lvl` is a thermometer code, so that a higher flag is never set while a lower one is clear. They also assume that both resets are held for at least two clocks before the first release. The bench only ever moves the supply by setting the number of asserted low-order flags, and it opens each run with a cold reset three clocks long. The host control inputs are changed one clock after an edge, so combinational pass-through is sampled without races.

// File: rtl/nvg_pkg.sv
package nvg_pkg;
    typedef enum logic [1:0] {
        ST_SEALED = 2'd0,
        ST_NORMAL = 2'd1,
        ST_PROT   = 2'd2,
        ST_BACKUP = 2'd3
    } nvg_state_e;

    // thermometer flag positions
    localparam int LVL_SWITCH = 0; // ~3.0 V
    localparam int LVL_SEAL   = 1; // 4.25 V
    localparam int LVL_MID    = 2; // 4.5 V
    localparam int LVL_FULL   = 3; // 4.75 V
    localparam int N_LVL      = 4;
endpackage

// File: rtl/nvg_sync.sv
module nvg_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stg[0] <= '0;
        else         stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) stg[i] <= '0;
            else         stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/nvg_fsm.sv
module nvg_fsm
    import nvg_pkg::*;
#(
    parameter bit TIGHT_TOL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cold_rst_n,
    input  logic [N_LVL-1:0] lvl_s,
    output nvg_state_e       st,
    output logic             seal_done
);
    localparam int PROT_IDX = TIGHT_TOL ? LVL_MID : LVL_SEAL;
    localparam int RES_IDX  = PROT_IDX + 1;

    nvg_state_e nxt;
    logic prot_ok, resume_ok;

    assign prot_ok   = lvl_s[PROT_IDX];
    assign resume_ok = lvl_s[RES_IDX];

    // seal memory survives warm reset
    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n)
            seal_done <= 1'b0;
        else if (rst_n && st == ST_SEALED && lvl_s[LVL_SEAL])
            seal_done <= 1'b1;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || !cold_rst_n)
            st <= (seal_done && cold_rst_n) ? ST_PROT : ST_SEALED;
        else
            st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_SEALED: if (lvl_s[LVL_SEAL]) nxt = resume_ok ? ST_NORMAL : ST_PROT;
            ST_NORMAL: if (!prot_ok) nxt = ST_PROT;
            ST_PROT: begin
                if (!lvl_s[LVL_SWITCH]) nxt = ST_BACKUP;
                else if (resume_ok)     nxt = ST_NORMAL;
            end
            ST_BACKUP: if (lvl_s[LVL_SWITCH]) nxt = ST_PROT;
            default:   nxt = ST_SEALED;
        endcase
    end
endmodule

// File: rtl/nvg_gate.sv
module nvg_gate
    import nvg_pkg::*;
(
    input  nvg_state_e st,
    input  logic       host_ce_n,
    input  logic       host_we_n,
    input  logic       host_oe_n,
    output logic       ram_ce_n,
    output logic       ram_we_n,
    output logic       ram_oe_n,
    output logic       dq_drive_en,
    output logic       backup_sel
);
    logic sel, wr, rd;

    assign sel = !host_ce_n;
    assign wr  = sel && !host_we_n;
    assign rd  = sel && !host_oe_n && host_we_n;

    always_comb begin
        ram_ce_n    = 1'b1;
        ram_we_n    = 1'b1;
        ram_oe_n    = 1'b1;
        dq_drive_en = 1'b0;
        backup_sel  = 1'b0;
        unique case (st)
            ST_NORMAL: begin
                ram_ce_n    = !sel;
                ram_we_n    = !wr;
                ram_oe_n    = !rd;
                dq_drive_en = rd;
            end
            ST_BACKUP: backup_sel = 1'b1;
            ST_SEALED, ST_PROT: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/nvsram_guard.sv
module nvsram_guard
    import nvg_pkg::*;
#(
    parameter bit TIGHT_TOL   = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cold_rst_n,
    input  logic [N_LVL-1:0] supply_lvl,
    input  logic             host_ce_n,
    input  logic             host_we_n,
    input  logic             host_oe_n,
    output logic             ram_ce_n,
    output logic             ram_we_n,
    output logic             ram_oe_n,
    output logic             dq_drive_en,
    output logic             backup_sel
);
    logic             any_rst_n;
    logic [N_LVL-1:0] lvl_s;
    nvg_state_e       st;
    logic             seal_done;

    assign any_rst_n = rst_n & cold_rst_n;

    nvg_sync #(.W(N_LVL), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .arst_n(any_rst_n), .d(supply_lvl), .q(lvl_s)
    );

    nvg_fsm #(.TIGHT_TOL(TIGHT_TOL)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n),
        .lvl_s(lvl_s), .st(st), .seal_done(seal_done)
    );

    nvg_gate u_gate (
        .st(st), .host_ce_n(host_ce_n), .host_we_n(host_we_n),
        .host_oe_n(host_oe_n), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n),
        .ram_oe_n(ram_oe_n), .dq_drive_en(dq_drive_en), .backup_sel(backup_sel)
    );
endmodule

// File: rtl/nvsram_guard_chk.sv
module nvsram_guard_chk
    import nvg_pkg::*;
#(
    parameter bit TIGHT_TOL = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cold_rst_n,
    input nvg_state_e       st,
    input logic             seal_done,
    input logic [N_LVL-1:0] lvl_s,
    input logic             host_we_n,
    input logic             ram_ce_n,
    input logic             ram_we_n,
    input logic             dq_drive_en,
    input logic             backup_sel
);
    localparam int RES_IDX = (TIGHT_TOL ? LVL_MID : LVL_SEAL) + 1;

    p_strobe_normal_r6: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
        !ram_we_n |-> st == ST_NORMAL);

    p_hiz_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
        st != ST_NORMAL |-> (!dq_drive_en && ram_ce_n));

    p_drive_off_write_r9: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
        dq_drive_en |-> host_we_n);

    p_seal_sticky_r3: assert property (@(posedge clk) disable iff (!cold_rst_n)
        seal_done |=> seal_done);

    p_sealed_no_backup_r2: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
        st == ST_SEALED |-> (!backup_sel && !seal_done));

    p_backup_armed_r11: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
        backup_sel |-> seal_done);

    p_resume_level_r5: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
        (st == ST_NORMAL && $past(st) != ST_NORMAL) |-> $past(lvl_s[RES_IDX]));

    p_cut_write_r10: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
        (st == ST_PROT && $past(st) == ST_NORMAL) |-> ram_we_n);
endmodule

bind nvsram_guard nvsram_guard_chk #(.TIGHT_TOL(TIGHT_TOL)) u_chk (
    .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n), .st(st),
    .seal_done(seal_done), .lvl_s(lvl_s), .host_we_n(host_we_n),
    .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .dq_drive_en(dq_drive_en),
    .backup_sel(backup_sel)
);

// File: tb/nvsram_guard_bench.sv
module nvsram_guard_bench;
    logic       clk = 1'b0;
    logic       rst_n, cold_rst_n;
    logic [3:0] supply_lvl;
    logic       host_ce_n, host_we_n, host_oe_n;
    logic       ram_ce_n, ram_we_n, ram_oe_n, dq_drive_en, backup_sel;
    logic       w_ce_n, w_we_n, w_oe_n, w_dq, w_bat;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    nvsram_guard u_nvsram_guard (
        .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n), .supply_lvl(supply_lvl),
        .host_ce_n(host_ce_n), .host_we_n(host_we_n), .host_oe_n(host_oe_n),
        .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
        .dq_drive_en(dq_drive_en), .backup_sel(backup_sel)
    );

    nvsram_guard #(.TIGHT_TOL(1'b0)) u_wide (
        .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n), .supply_lvl(supply_lvl),
        .host_ce_n(host_ce_n), .host_we_n(host_we_n), .host_oe_n(host_oe_n),
        .ram_ce_n(w_ce_n), .ram_we_n(w_we_n), .ram_oe_n(w_oe_n),
        .dq_drive_en(w_dq), .backup_sel(w_bat)
    );

    task automatic chk(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_lvl(input int n);
        supply_lvl = 4'((1 << n) - 1);
    endtask

    task automatic host(input logic ce, input logic we, input logic oe);
        host_ce_n = ce; host_we_n = we; host_oe_n = oe;
        #0.5;
    endtask

    task automatic do_cold_reset();
        rst_n = 1'b0; cold_rst_n = 1'b0; supply_lvl = '0;
        host_ce_n = 1'b1; host_we_n = 1'b1; host_oe_n = 1'b1;
        step(3);
        rst_n = 1'b1; cold_rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_reset();
        do_cold_reset();
        chk("R6 reset ram_ce_n", ram_ce_n, 1'b1);
        chk("R6 reset ram_we_n", ram_we_n, 1'b1);
        chk("R6 reset ram_oe_n", ram_oe_n, 1'b1);
        chk("R6 reset dq_drive_en", dq_drive_en, 1'b0);
        chk("R2 reset backup_sel", backup_sel, 1'b0);
    endtask

    task automatic t_sealed();
        set_lvl(1); host(1'b0, 1'b1, 1'b0); step(5);
        chk("R2 sealed above switchover backup", backup_sel, 1'b0);
        chk("R6 sealed ce blocked", ram_ce_n, 1'b1);
        chk("R6 sealed drivers off", dq_drive_en, 1'b0);
        set_lvl(0); step(5);
        chk("R2 sealed below switchover backup", backup_sel, 1'b0);
        host(1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_powerup_read();
        set_lvl(4); step(5);
        host(1'b0, 1'b1, 1'b0);
        chk("R7 read ce passes", ram_ce_n, 1'b0);
        chk("R7 read oe passes", ram_oe_n, 1'b0);
        chk("R7 read drivers on", dq_drive_en, 1'b1);
        chk("R8 read no strobe", ram_we_n, 1'b1);
        chk("R12 wide read drivers on", w_dq, 1'b1);
        host(1'b1, 1'b1, 1'b0);
        chk("R7 deselect ce", ram_ce_n, 1'b1);
    endtask

    task automatic t_write_edges();
        host(1'b0, 1'b1, 1'b0);
        chk("R7 drivers before write", dq_drive_en, 1'b1);
        host(1'b0, 1'b0, 1'b0);
        chk("R9 we fall drops drivers", dq_drive_en, 1'b0);
        chk("R9 we fall drops ram_oe_n", ram_oe_n, 1'b1);
        chk("R8 later falling starts strobe", ram_we_n, 1'b0);
        host(1'b1, 1'b0, 1'b1);
        chk("R8 ce rise ends strobe", ram_we_n, 1'b1);
        host(1'b0, 1'b0, 1'b1);
        chk("R8 ce fall with we low starts strobe", ram_we_n, 1'b0);
        host(1'b0, 1'b1, 1'b1);
        chk("R8 we rise ends strobe", ram_we_n, 1'b1);
        host(1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_write_cut();
        host(1'b0, 1'b0, 1'b1);
        set_lvl(2);
        step(2);
        chk("R1 strobe held two edges", ram_we_n, 1'b0);
        chk("R12 wide strobe held", w_we_n, 1'b0);
        step(1);
        chk("R10 strobe cut on protect entry", ram_we_n, 1'b1);
        chk("R4 tight protects below 4.5V", ram_ce_n, 1'b1);
        chk("R12 wide still writing at 4.25-4.5V", w_we_n, 1'b0);
    endtask

    task automatic t_hysteresis();
        set_lvl(1); step(4);
        chk("R4 wide protects below 4.25V", w_we_n, 1'b1);
        set_lvl(2); step(5);
        chk("R5 wide blocked between levels", w_we_n, 1'b1);
        set_lvl(3); step(5);
        chk("R5 wide resumes at 4.5V", w_we_n, 1'b0);
        chk("R5 tight blocked below 4.75V", ram_we_n, 1'b1);
        set_lvl(4); step(5);
        chk("R5 tight resumes at 4.75V", ram_we_n, 1'b0);
        host(1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_backup();
        set_lvl(0); step(6);
        host(1'b0, 1'b1, 1'b0);
        chk("R11 backup selected below switchover", backup_sel, 1'b1);
        chk("R6 backup drivers off", dq_drive_en, 1'b0);
        chk("R6 backup ce blocked", ram_ce_n, 1'b1);
        set_lvl(1); step(5);
        chk("R11 backup released above switchover", backup_sel, 1'b0);
        chk("R6 still protected after switchback", ram_ce_n, 1'b1);
        set_lvl(0); step(6);
        chk("R11 backup again", backup_sel, 1'b1);
        host(1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_warm_reset();
        rst_n = 1'b0; step(2);
        rst_n = 1'b1; step(4);
        chk("R3 seal kept across warm reset", backup_sel, 1'b1);
        chk("R3 wide seal kept", w_bat, 1'b1);
        do_cold_reset();
        step(4);
        chk("R3 cold reset reseals", backup_sel, 1'b0);
        set_lvl(4); step(5);
        host(1'b0, 1'b1, 1'b0);
        chk("R2 release after reseal", dq_drive_en, 1'b1);
        host(1'b1, 1'b1, 1'b1);
    endtask

    initial begin
        t_reset();
        t_sealed();
        t_powerup_read();
        t_write_edges();
        t_write_cut();
        t_hysteresis();
        t_backup();
        t_warm_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule